// File: doc/BRIEF.md
# Multi-Lane SPI Memory Access Slave

This block is a SPI slave that gives an external master read and write access to a 22-bit byte-addressed internal memory space. It works in SPI mode 0: it samples on the rising edge of the serial clock and changes its outputs on the falling edge. Each transaction is framed by an active-low chip select. A transaction opens with a three-byte header that carries a two-bit operation code and the byte address. A write then carries any number of data bytes. A read inserts one dummy byte and then streams data bytes until chip select rises. The address steps by one per data byte, so one header can start a burst of any length.

The block can move one, two or four bits per clock. The lane count sits in a small width register that the master writes through the slave itself, and a new count takes effect with the next transaction. Each data line has its own input, output and output enable. The block leaves every line as an input until it shifts out the first read data byte. The dummy byte is therefore a turnaround period in which neither side drives. On the memory side there is a plain synchronous bus clocked by the serial clock. Write strobe, address and data are valid during the rising edge that completes a byte. A read request is answered on the read data input after that edge.

Top module: `qspi_mem_slave`

## Requirements
- R1: Out of reset all output enables are 0, neither memory strobe is active, and the lane mode is single.
- R2: A write data byte whose address equals WIDTH_ADDR (default 22'h3FFFFC) loads the lane code from data bits [1:0] (00 single, 01 dual, 10 quad) and does not reach the memory bus. Code 11 is ignored. A read of that address returns {6'b0, code}.
- R3: A new lane code applies from the next transaction on. The rest of the transaction that wrote it keeps the old lane count.
- R4: Header byte 0 holds the operation in bits [7:6] (00 read, 10 write) and address bits [21:16] in bits [5:0]. Byte 1 holds address [15:8] and byte 2 holds address [7:0]. Operations 01 and 11 cause no memory access and no drive.
- R5: For each complete write data byte, mem_we_o is high during the rising edge that takes in its last bits, with mem_addr_o and mem_wdata_o valid.
- R6: The address increases by one after every data byte of a burst, for reads and writes alike, with carry across byte boundaries.
- R7: On a read, byte 3 is a dummy byte with all output enables 0. Drive starts at the falling edge after the last rising edge of the dummy byte, together with the first bits of read data.
- R8: Single mode takes input on dq[0] and drives dq[1]. Dual mode uses dq[1:0] with dq[1] the more significant bit. Quad mode uses dq[3:0] with dq[3] most significant. Every mode sends the most significant bits of a byte first.
- R9: While read data is driven, the output enable is 4'b0010 in single mode, 4'b0011 in dual mode and 4'b1111 in quad mode.
- R10: Raising chip select clears every output enable at once, even partway through a byte. A partly received byte writes nothing. Every transaction begins with all lines as inputs.
- R11: mem_re_o is high during the last rising edge of the dummy byte and of each read data byte, with the address of the next byte to send. Its data is taken from mem_rdata_i after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk_i | input | 1 | SPI serial clock; also clocks the memory bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Active-low chip select |
| dq_i | input | 4 | Data line inputs |
| dq_o | output | 4 | Data line outputs |
| dq_oe_o | output | 4 | Data line output enables, 1 = drive |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read request |
| mem_rdata_i | input | 8 | Memory read data, valid after the edge of a read request |

## Verification
The write strobe and the read request are combinational during the rising edge that completes a byte, so they are due in the same clock as the last bits of that byte. Read data and the output enable are due half a clock later, after the next falling edge. Clearing the enables on chip select rise needs no clock edge at all. The bench sets the master's bits while the clock is low and samples every slave output half a period after the falling edge, just before the rising edge. At that point it compares the enables and both strobes against a behavioural model on every clock. It checks the clearing of the enables one time step after chip select rises.

// File: rtl/qspi_slv_pkg.sv
package qspi_slv_pkg;
  localparam int BYTE_W   = 8;
  localparam int LANES    = 4;
  localparam int BEAT_W   = 3;
  localparam int IDX_W    = 3;
  localparam logic [IDX_W-1:0] IDX_DATA  = 3'd3;  // first write byte / read dummy
  localparam logic [IDX_W-1:0] IDX_RDATA = 3'd4;  // read data (saturates here)

  typedef enum logic [1:0] {
    LM_SINGLE = 2'b00,
    LM_DUAL   = 2'b01,
    LM_QUAD   = 2'b10,
    LM_RSVD   = 2'b11
  } lane_mode_e;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_NOP1  = 2'b01,
    OP_WRITE = 2'b10,
    OP_NOP3  = 2'b11
  } op_e;

  function automatic logic [BEAT_W-1:0] last_beat(lane_mode_e m);
    case (m)
      LM_DUAL: return 3'd3;
      LM_QUAD: return 3'd1;
      default: return 3'd7;
    endcase
  endfunction

  function automatic logic [LANES-1:0] oe_mask(lane_mode_e m);
    case (m)
      LM_DUAL: return 4'b0011;
      LM_QUAD: return 4'b1111;
      default: return 4'b0010;
    endcase
  endfunction
endpackage

// File: rtl/qspi_slv_rx.sv
module qspi_slv_rx
  import qspi_slv_pkg::*;
(
  input  logic              sclk_i,
  input  logic              txn_rst_ni,
  input  lane_mode_e        mode_i,
  input  logic [LANES-1:0]  dq_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_done_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [BEAT_W-1:0] beat_o
);
  logic [BYTE_W-1:0] sh_q;
  logic [BEAT_W-1:0] beat_q;
  logic [IDX_W-1:0]  idx_q;

  always_comb begin
    case (mode_i)
      LM_DUAL: byte_o = {sh_q[BYTE_W-3:0], dq_i[1:0]};
      LM_QUAD: byte_o = {sh_q[BYTE_W-5:0], dq_i};
      default: byte_o = {sh_q[BYTE_W-2:0], dq_i[0]};
    endcase
  end

  assign byte_done_o = (beat_q == last_beat(mode_i));
  assign idx_o       = idx_q;
  assign beat_o      = beat_q;

  always_ff @(posedge sclk_i or negedge txn_rst_ni) begin
    if (!txn_rst_ni) begin
      sh_q   <= '0;
      beat_q <= '0;
      idx_q  <= '0;
    end else begin
      sh_q <= byte_o;
      if (byte_done_o) begin
        beat_q <= '0;
        if (idx_q != IDX_RDATA) idx_q <= idx_q + 1'b1;
      end else begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/qspi_slv_ctrl.sv
module qspi_slv_ctrl
  import qspi_slv_pkg::*;
#(
  parameter int                ADDR_W     = 22,
  parameter logic [ADDR_W-1:0] WIDTH_ADDR = 22'h3FFFFC
) (
  input  logic              sclk_i,
  input  logic              rst_ni,
  input  logic              txn_rst_ni,
  input  logic              cs_n_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_done_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output lane_mode_e        mode_o,
  output logic [1:0]        width_code_o,
  output logic              rd_width_o,
  output logic              rd_phase_o
);
  localparam int HI_W = ADDR_W - 16;

  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        pend_q;
  lane_mode_e        mode_q;
  logic              rd_width_q;
  logic              is_wr, is_rd, in_data, hit_width, wr_beat;

  assign is_wr     = (op_q == OP_WRITE);
  assign is_rd     = (op_q == OP_READ);
  assign in_data   = (idx_i >= IDX_DATA);
  assign hit_width = (addr_q == WIDTH_ADDR);
  assign wr_beat   = byte_done_i && is_wr && in_data;

  assign mem_addr_o   = addr_q;
  assign mem_wdata_o  = byte_i;
  assign mem_we_o     = wr_beat && !hit_width;
  assign mem_re_o     = byte_done_i && is_rd && in_data;
  assign mode_o       = mode_q;
  assign width_code_o = pend_q;
  assign rd_width_o   = rd_width_q;
  assign rd_phase_o   = is_rd && (idx_i == IDX_RDATA);

  always_ff @(posedge sclk_i or negedge txn_rst_ni) begin
    if (!txn_rst_ni) begin
      op_q       <= OP_NOP3;
      addr_q     <= '0;
      rd_width_q <= 1'b0;
    end else if (byte_done_i) begin
      case (idx_i)
        3'd0: begin
          op_q                  <= op_e'(byte_i[BYTE_W-1 -: 2]);
          addr_q[ADDR_W-1:16]   <= byte_i[HI_W-1:0];
        end
        3'd1: addr_q[15:8] <= byte_i;
        3'd2: addr_q[7:0]  <= byte_i;
        default: begin
          if (wr_beat || mem_re_o) addr_q <= addr_q + 1'b1;
          if (mem_re_o) rd_width_q <= hit_width;
        end
      endcase
    end
  end

  // lane code survives transactions; reserved code is dropped
  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= LM_SINGLE;
    else if (wr_beat && hit_width && byte_i[1:0] != LM_RSVD) pend_q <= byte_i[1:0];
  end

  // applied only between transactions
  always_ff @(posedge cs_n_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= LM_SINGLE;
    else         mode_q <= lane_mode_e'(pend_q);
  end
endmodule

// File: rtl/qspi_slv_tx.sv
module qspi_slv_tx
  import qspi_slv_pkg::*;
(
  input  logic              sclk_i,
  input  logic              txn_rst_ni,
  input  lane_mode_e        mode_i,
  input  logic              rd_phase_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  logic [BYTE_W-1:0] load_i,
  output logic [LANES-1:0]  dq_o,
  output logic [LANES-1:0]  dq_oe_o
);
  logic [BYTE_W-1:0] tx_q;
  logic [BYTE_W-1:0] tx_shift;
  logic              oe_q;

  always_comb begin
    case (mode_i)
      LM_DUAL: tx_shift = {tx_q[BYTE_W-3:0], 2'b00};
      LM_QUAD: tx_shift = {tx_q[BYTE_W-5:0], 4'b0000};
      default: tx_shift = {tx_q[BYTE_W-2:0], 1'b0};
    endcase
  end

  always_ff @(negedge sclk_i or negedge txn_rst_ni) begin
    if (!txn_rst_ni) begin
      tx_q <= '0;
      oe_q <= 1'b0;
    end else if (rd_phase_i) begin
      oe_q <= 1'b1;
      tx_q <= (beat_i == '0) ? load_i : tx_shift;
    end
  end

  always_comb begin
    case (mode_i)
      LM_DUAL: dq_o = {2'b00, tx_q[BYTE_W-1 -: 2]};
      LM_QUAD: dq_o = tx_q[BYTE_W-1 -: 4];
      default: dq_o = {2'b00, tx_q[BYTE_W-1], 1'b0};
    endcase
  end

  assign dq_oe_o = oe_q ? oe_mask(mode_i) : '0;
endmodule

// File: rtl/qspi_mem_slave.sv
module qspi_mem_slave
  import qspi_slv_pkg::*;
#(
  parameter int                ADDR_W     = 22,
  parameter logic [ADDR_W-1:0] WIDTH_ADDR = 22'h3FFFFC
) (
  input  logic              sclk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic [3:0]        dq_i,
  output logic [3:0]        dq_o,
  output logic [3:0]        dq_oe_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  input  logic [7:0]        mem_rdata_i
);
  logic              txn_rst_n;
  lane_mode_e        mode;
  logic [BYTE_W-1:0] rx_byte;
  logic              rx_done;
  logic [IDX_W-1:0]  rx_idx;
  logic [BEAT_W-1:0] rx_beat;
  logic [1:0]        width_code;
  logic              rd_width;
  logic              rd_phase;
  logic [BYTE_W-1:0] tx_load;

  assign txn_rst_n = rst_ni & ~cs_n_i;
  assign tx_load   = rd_width ? {{(BYTE_W-2){1'b0}}, width_code} : mem_rdata_i;

  qspi_slv_rx u_rx (
    .sclk_i      (sclk_i),
    .txn_rst_ni  (txn_rst_n),
    .mode_i      (mode),
    .dq_i        (dq_i),
    .byte_o      (rx_byte),
    .byte_done_o (rx_done),
    .idx_o       (rx_idx),
    .beat_o      (rx_beat)
  );

  qspi_slv_ctrl #(.ADDR_W(ADDR_W), .WIDTH_ADDR(WIDTH_ADDR)) u_ctrl (
    .sclk_i       (sclk_i),
    .rst_ni       (rst_ni),
    .txn_rst_ni   (txn_rst_n),
    .cs_n_i       (cs_n_i),
    .byte_i       (rx_byte),
    .byte_done_i  (rx_done),
    .idx_i        (rx_idx),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_we_o     (mem_we_o),
    .mem_re_o     (mem_re_o),
    .mode_o       (mode),
    .width_code_o (width_code),
    .rd_width_o   (rd_width),
    .rd_phase_o   (rd_phase)
  );

  qspi_slv_tx u_tx (
    .sclk_i     (sclk_i),
    .txn_rst_ni (txn_rst_n),
    .mode_i     (mode),
    .rd_phase_i (rd_phase),
    .beat_i     (rx_beat),
    .load_i     (tx_load),
    .dq_o       (dq_o),
    .dq_oe_o    (dq_oe_o)
  );
endmodule

// File: rtl/qspi_mem_slave_chk.sv
module qspi_mem_slave_chk #(
  parameter int ADDR_W = 22
) (
  input logic              sclk_i,
  input logic              rst_ni,
  input logic              cs_n_i,
  input logic [3:0]        dq_oe_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_we_o,
  input logic              mem_re_o
);
  logic              acc_q;
  logic [ADDR_W-1:0] prev_q;

  always_ff @(posedge sclk_i or posedge cs_n_i) begin
    if (cs_n_i) begin
      acc_q  <= 1'b0;
      prev_q <= '0;
    end else begin
      acc_q  <= mem_we_o || mem_re_o;
      prev_q <= mem_addr_o;
    end
  end

  always @(negedge cs_n_i) begin
    if (rst_ni === 1'b1)
      AST_START_AS_INPUT: assert (dq_oe_o == 4'b0000) else $error("oe set at start"); // R10
  end

  AST_ONE_ACCESS: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o)); // R5

  AST_OE_SHAPE: assert property (@(negedge sclk_i) disable iff (!rst_ni)
    (dq_oe_o == 4'b0000 || dq_oe_o == 4'b0010 || dq_oe_o == 4'b0011 || dq_oe_o == 4'b1111)); // R9

  AST_ADDR_STEP: assert property (@(posedge sclk_i) disable iff (!rst_ni || cs_n_i)
    acc_q |-> (mem_addr_o == prev_q + 1'b1)); // R6
endmodule

bind qspi_mem_slave qspi_mem_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .sclk_i     (sclk_i),
  .rst_ni     (rst_ni),
  .cs_n_i     (cs_n_i),
  .dq_oe_o    (dq_oe_o),
  .mem_addr_o (mem_addr_o),
  .mem_we_o   (mem_we_o),
  .mem_re_o   (mem_re_o)
);

// File: tb/sim_qspi_mem_slave.sv
module sim_qspi_mem_slave;
  localparam int          CLK_PERIOD = 20;
  localparam int          HALF       = CLK_PERIOD / 2;
  localparam logic [21:0] WADDR      = 22'h3FFFFC;

  logic        sclk = 1'b0, rst_n = 1'b0, cs_n = 1'b1;
  logic [3:0]  dq_in = 4'h0;
  logic [3:0]  dq_out, dq_oe;
  logic [21:0] maddr;
  logic [7:0]  mwdata, mrdata = 8'h00;
  logic        mwe, mre;

  int n_chk = 0, n_err = 0;
  int cur_mode = 0, pend_mode = 0;
  logic [7:0] bus_mem [logic [21:0]];
  logic [7:0] ref_mem [logic [21:0]];
  logic [7:0] wq [$];

  qspi_mem_slave u0 (
    .sclk_i(sclk), .rst_ni(rst_n), .cs_n_i(cs_n), .dq_i(dq_in), .dq_o(dq_out),
    .dq_oe_o(dq_oe), .mem_addr_o(maddr), .mem_wdata_o(mwdata), .mem_we_o(mwe),
    .mem_re_o(mre), .mem_rdata_i(mrdata)
  );

  // synchronous memory model on the bus
  always @(posedge sclk) begin
    if (mwe) bus_mem[maddr] = mwdata;
    if (mre) mrdata <= bus_mem.exists(maddr) ? bus_mem[maddr] : 8'h00;
  end

  function automatic logic [7:0] ref_rd(logic [21:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
  endfunction

  function automatic logic [3:0] mask_of(int m);
    return (m == 2) ? 4'b1111 : (m == 1) ? 4'b0011 : 4'b0010;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // one transaction; op 00 read, 10 write, others idle; cut<0 runs it in full
  task automatic txn(input logic [1:0] op, input logic [21:0] a, input int nrd, input int cut);
    logic [7:0] seq [$];
    int   lw = 1 << cur_mode;
    int   beats = 8 >> cur_mode;
    int   cnt = 0;
    bit   stop = 0;
    bit   is_rd = (op == 2'b00);
    bit   is_wr = (op == 2'b10);
    seq = {};
    seq.push_back({op, a[21:16]});
    seq.push_back(a[15:8]);
    seq.push_back(a[7:0]);
    if (is_rd) begin
      for (int j = 0; j <= nrd; j++) seq.push_back(8'h00);
    end else begin
      foreach (wq[j]) seq.push_back(wq[j]);
    end
    cs_n = 1'b0;
    #HALF;
    for (int i = 0; i < seq.size(); i++) begin
      logic [7:0]  got = 8'h00;
      logic [21:0] ba = a + 22'(i - 3);
      for (int k = 0; k < beats; k++) begin
        logic [3:0] sl;
        bit last, e_we, e_re;
        logic [3:0] e_oe;
        if (cut >= 0 && cnt == cut) begin stop = 1; break; end
        cnt++;
        sl = 4'((seq[i] >> (8 - lw * (k + 1))) & ((1 << lw) - 1));
        dq_in = (cur_mode == 0) ? {3'b000, sl[0]} : sl;
        last = (k == beats - 1);
        e_oe = (is_rd && i >= 4) ? mask_of(cur_mode) : 4'b0000;
        e_we = last && is_wr && i >= 3 && ba != WADDR;
        e_re = last && is_rd && i >= 3;
        #HALF;
        chk("R7/R9/R10 output enable", dq_oe, e_oe);
        chk("R5/R4 write strobe", mwe, e_we);
        chk("R11/R4 read request", mre, e_re);
        if (e_we || e_re) chk("R6 bus address", maddr, ba);
        if (e_we) chk("R5 write data", mwdata, seq[i]);
        if (cur_mode == 0)      got = {got[6:0], dq_out[1]};
        else if (cur_mode == 1) got = {got[5:0], dq_out[1:0]};
        else                    got = {got[3:0], dq_out};
        if (last && is_wr && i >= 3) begin
          if (ba == WADDR) begin
            if (seq[i][1:0] != 2'b11) pend_mode = int'(seq[i][1:0]);
          end else ref_mem[ba] = seq[i];
        end
        sclk = 1'b1;
        #HALF;
        sclk = 1'b0;
      end
      if (stop) break;
      if (is_rd && i >= 4) begin
        logic [21:0] ra = a + 22'(i - 4);
        logic [7:0]  ev = (ra == WADDR) ? {6'b0, 2'(pend_mode)} : ref_rd(ra);
        chk("R8/R7 read byte", got, ev);
      end
    end
    dq_in = 4'h0;
    #HALF;
    cs_n = 1'b1;
    #1;
    chk("R10 oe after cs high", dq_oe, 4'b0000);
    cur_mode = pend_mode;
    #(HALF - 1);
  endtask

  initial begin
    #(200000 * CLK_PERIOD);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(3 * CLK_PERIOD);
    chk("R1 reset oe", dq_oe, 4'b0000);
    chk("R1 reset we", mwe, 1'b0);
    chk("R1 reset re", mre, 1'b0);
    rst_n = 1'b1;
    #CLK_PERIOD;

    // R1 R5 R6: single-lane write burst, then read back
    wq = {};
    wq.push_back(8'hA5); wq.push_back(8'h3C); wq.push_back(8'hF0);
    txn(2'b10, 22'h012345, 0, -1);
    chk("R5 bus mem 012347", bus_mem.exists(22'h012347) ? bus_mem[22'h012347] : 8'hXX, 8'hF0);
    txn(2'b00, 22'h012345, 3, -1);

    // R2 R3: select dual, continue burst in single lane
    wq = {};
    wq.push_back(8'h01); wq.push_back(8'h77);
    txn(2'b10, WADDR, 0, -1);
    chk("R2 width not on bus", bus_mem.exists(WADDR), 0);
    chk("R3 byte after width write", bus_mem.exists(22'h3FFFFD) ? bus_mem[22'h3FFFFD] : 8'hXX, 8'h77);

    // R6 R8 dual burst across a byte boundary
    wq = {};
    wq.push_back(8'h11); wq.push_back(8'h22); wq.push_back(8'h33); wq.push_back(8'h44);
    txn(2'b10, 22'h0000FE, 0, -1);
    txn(2'b00, 22'h0000FE, 4, -1);
    txn(2'b00, WADDR, 1, -1);

    // R2 reserved code ignored
    wq = {};
    wq.push_back(8'h03);
    txn(2'b10, WADDR, 0, -1);
    txn(2'b00, WADDR, 1, -1);

    // quad
    wq = {};
    wq.push_back(8'h02);
    txn(2'b10, WADDR, 0, -1);
    wq = {};
    wq.push_back(8'h9E); wq.push_back(8'h61); wq.push_back(8'hC7);
    wq.push_back(8'h08); wq.push_back(8'hB3);
    txn(2'b10, 22'h2ABCDE, 0, -1);
    txn(2'b00, 22'h2ABCDE, 5, -1);

    // R4 undefined operation code
    wq = {};
    wq.push_back(8'hFF);
    txn(2'b01, 22'h012345, 0, -1);
    txn(2'b11, 22'h012346, 0, -1);
    txn(2'b00, 22'h012345, 2, -1);

    // R10 aborts: read mid data byte, write mid data byte
    txn(2'b00, 22'h2ABCDE, 2, 11);
    wq = {};
    wq.push_back(8'h5A);
    txn(2'b10, 22'h000010, 0, 7);
    chk("R10 partial byte not written", bus_mem.exists(22'h000010), 0);

    // back to single
    wq = {};
    wq.push_back(8'h00);
    txn(2'b10, WADDR, 0, -1);
    txn(2'b00, 22'h012345, 1, -1);

    foreach (ref_mem[a]) chk("R5 bus mem vs model", bus_mem.exists(a) ? bus_mem[a] : 8'hXX, ref_mem[a]);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule